// File: doc/BRIEF.md
# RTC Calibrated Seconds Prescaler

This block turns a 32.768 kHz count enable into a one-second tick for a real-time clock. It can trim the oscillator's drift digitally. At the start of every 16-second window the prescaler either swallows some counted enables or double-steps on some of them. How many and which way is set by a signed calibration value held in a small register bank.

Two 8-bit registers sit on a simple synchronous write port with a combinational read port. The control register has a calibration-mode bit and an oscillator-halt bit. The calibration register holds the correction magnitude and sign, and it accepts writes only while calibration mode is on.

In calibration mode a shared output pin carries a nominal 512 Hz square wave taken from the uncorrected count. A technician can measure the crystal error on it. Otherwise the pin passes an alternate (power-fail) signal through. The calibration register has no reset, so it keeps its value across an ordinary reset.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: Writing address 0x00 sets the control register; its bit 6 is the calibration-mode flag (1 enters, 0 exits), and a read of address 0x00 returns the last byte written there.
- R2: While control bit 6 is 1, `shared_out` carries the uncorrected tone, which is bit (DIV_BITS-10) of the window count and is 512 Hz for a 32.768 kHz enable. While bit 6 is 0, `shared_out` follows `alt_in`.
- R3: The calibration register at address 0x01 holds a magnitude in bits 4:0 and a sign in bit 5. A read returns those six bits, with bits 7:6 as zero.
- R4: A write to address 0x01 while control bit 6 is 0 is ignored, and the stored calibration value is unchanged.
- R5: Reset clears the control register to 0x00 and the window and divider counts to zero. The calibration register keeps its value through reset.
- R6: With no correction, `sec_tick` pulses on every 2^DIV_BITS-th counted enable.
- R7: With magnitude m > 0, the first 2*m counted enables of each 2^WIN_BITS window are adjusted. With sign 1 each of them advances the divider by 2; with sign 0 each is ignored by the divider.
- R8: A magnitude of zero applies no correction, whatever the sign bit holds.
- R9: Each divider wrap gives exactly one `sec_tick` pulse, and the divider count just after a tick is 0 or 1.
- R10: Control bit 7 set to 1 halts the oscillator path. The divider and window counts freeze and `sec_tick` stays low while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | One-cycle pulse per oscillator period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for read and write |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` |
| alt_in | input | 1 | Alternate (power-fail) signal for the shared pin |
| sec_tick | output | 1 | One-cycle pulse per corrected second |
| shared_out | output | 1 | Calibration tone or alternate signal |

## Verification
The assertions check on every cycle that:
- the calibration value never changes outside calibration mode;
- the counts hold still while halted or between enables;
- an uncorrected step advances the divider by exactly one;
- every tick lands the divider at 0 or 1;
- the shared pin holds steady between counted enables in calibration mode.

Only the bench scenarios can show the exact arithmetic of a correction. They compare the enable count to the first tick for adding, removing and zero-magnitude settings, and the tick total over whole windows. They also show that the calibration value survives reset and that a write outside calibration mode is discarded.

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler #(
  parameter int DIV_BITS = 15,
  parameter int WIN_BITS = 19,
  parameter int MAG_BITS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       alt_in,
  output logic       sec_tick,
  output logic       shared_out
);
  localparam int TONE_BIT = DIV_BITS - 10;
  localparam int CAL_W    = MAG_BITS + 1;

  logic [7:0]          ctrl_q;
  logic [CAL_W-1:0]    cal_q;
  logic [DIV_BITS-1:0] div_q;
  logic [WIN_BITS-1:0] win_q;

  wire                cal_mode = ctrl_q[6];
  wire                halt     = ctrl_q[7];
  wire                step     = cnt_en & ~halt;
  wire [MAG_BITS-1:0] mag      = cal_q[MAG_BITS-1:0];
  wire                sgn      = cal_q[MAG_BITS];
  wire                adjust   = (mag != '0) && (win_q < WIN_BITS'({mag, 1'b0}));
  wire [1:0]          inc      = !adjust ? 2'd1 : (sgn ? 2'd2 : 2'd0);
  wire [DIV_BITS:0]   sum      = {1'b0, div_q} + (DIV_BITS+1)'(inc);

  assign sec_tick   = step & sum[DIV_BITS];
  assign shared_out = cal_mode ? win_q[TONE_BIT] : alt_in;
  assign rdata      = (addr == 8'h00) ? ctrl_q :
                      (addr == 8'h01) ? 8'(cal_q) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      win_q  <= '0;
    end else begin
      if (wr_en && addr == 8'h00) ctrl_q <= wdata;
      if (step) begin
        div_q <= sum[DIV_BITS-1:0];
        win_q <= win_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && addr == 8'h01 && cal_mode) cal_q <= wdata[CAL_W-1:0];
  end

  assert_cal_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_mode |=> $stable(cal_q));

  assert_halt_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(div_q) && $stable(win_q)));

  assert_halt_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !sec_tick);

  assert_zero_mag_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && mag == '0) |=> div_q == $past(div_q) + 1'b1);

  assert_single_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> div_q < DIV_BITS'(2));

  assert_tone_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_mode && !step && !wr_en) |=> $stable(shared_out));
endmodule

// File: tb/sim_rtc_cal_prescaler.sv
module sim_rtc_cal_prescaler;
  localparam int DIVB = 10;
  localparam int WINB = 14;
  localparam int PER  = 1 << DIVB;
  localparam int WIN  = 1 << WINB;

  logic clk = 0, rst_n = 0, cnt_en = 0, wr_en = 0, alt_in = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic sec_tick, shared_out;

  int checks = 0, errors = 0;
  int phase = 0, mwin = 0;
  logic [7:0] mctrl = 0;
  logic [5:0] mcal = 0;
  bit mcal_ok = 0;
  bit done = 0;
  logic tk;
  logic [7:0] last_rd;

  rtc_cal_prescaler #(.DIV_BITS(DIVB), .WIN_BITS(WINB), .MAG_BITS(5)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .alt_in(alt_in), .sec_tick(sec_tick),
    .shared_out(shared_out));

  always #10 clk = ~clk;

  function automatic int first_tick(input int m, input bit s);
    if (m == 0) return PER;
    return s ? PER - 2*m : PER + 2*m;
  endfunction

  function automatic int ticks_over(input int wins, input int m, input bit s);
    int counts = wins * WIN;
    if (m != 0) counts += wins * (s ? 2*m : -2*m);
    return counts / PER;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic w, input logic [7:0] a,
                     input logic [7:0] d, input logic al, output logic t);
    int m, inc, etk, esh, erd;
    bit s, stp, adj;
    @(negedge clk);
    cnt_en = en; wr_en = w; addr = a; wdata = d; alt_in = al;
    #1;
    m = int'(mcal[4:0]); s = mcal[5];
    stp = en && !mctrl[7];
    adj = (m != 0) && (mwin < 2*m);
    inc = !stp ? 0 : (adj ? (s ? 2 : 0) : 1);
    etk = (stp && (phase + inc >= PER)) ? 1 : 0;
    esh = mctrl[6] ? ((mwin >> (DIVB-10)) & 1) : int'(al);
    erd = (a == 8'h00) ? int'(mctrl) : (a == 8'h01) ? int'(mcal) : 0;
    chk("R6/R7/R9 sec_tick", int'(sec_tick), etk);
    chk("R2 shared_out", int'(shared_out), esh);
    if (a != 8'h01 || mcal_ok) chk("R1/R3 rdata", int'(rdata), erd);
    t = sec_tick; last_rd = rdata;
    phase = (phase + inc) % PER;
    if (stp) mwin = (mwin + 1) % WIN;
    if (w && a == 8'h01 && mctrl[6]) begin mcal = d[5:0]; mcal_ok = 1; end
    if (w && a == 8'h00) mctrl = d;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    logic t; cyc(0, 1, a, d, 0, t);
  endtask

  task automatic rreg(input logic [7:0] a);
    logic t; cyc(0, 0, a, 0, 0, t);
  endtask

  task automatic do_reset;
    @(negedge clk);
    cnt_en = 0; wr_en = 0; rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    phase = 0; mwin = 0; mctrl = 0;
  endtask

  task automatic set_cal(input logic [5:0] v);
    wreg(8'h00, 8'h40); wreg(8'h01, {2'b00, v}); wreg(8'h00, 8'h00);
  endtask

  task automatic first_tick_run(input logic [5:0] v, input string req);
    int n = 0;
    logic t = 0;
    set_cal(v);
    do_reset();
    while (!t && n < 3*PER) begin
      cyc(1, 0, 8'h00, 0, 0, t);
      n++;
    end
    chk(req, n, first_tick(int'(v[4:0]), v[5]));
  endtask

  initial begin
    int n;
    logic t;
    void'($urandom(32'd2024));
    do_reset();
    rreg(8'h00); chk("R5 control after reset", int'(last_rd), 0);

    wreg(8'h00, 8'h40); rreg(8'h00); chk("R1 cal mode set", int'(last_rd), 8'h40);
    wreg(8'h01, 8'hFF); rreg(8'h01); chk("R3 cal readback", int'(last_rd), 8'h3F);
    wreg(8'h00, 8'h00); wreg(8'h01, 8'h05); rreg(8'h01);
    chk("R4 write ignored outside cal", int'(last_rd), 8'h3F);
    do_reset(); rreg(8'h01); chk("R5 cal kept over reset", int'(last_rd), 8'h3F);

    first_tick_run(6'h3F, "R7 add m=31");
    first_tick_run(6'h1F, "R7 remove m=31");
    first_tick_run(6'h20, "R8 zero magnitude sign 1");
    first_tick_run(6'h00, "R6 nominal period");

    wreg(8'h00, 8'h80);
    n = 0;
    for (int i = 0; i < 3000; i++) begin cyc(1, 0, 8'h00, 0, 0, t); n += int'(t); end
    chk("R10 no ticks while halted", n, 0);
    wreg(8'h00, 8'h00);

    cyc(0, 0, 8'h00, 0, 1, t); chk("R2 alt passes when cal off", int'(shared_out), 1);
    wreg(8'h00, 8'h40);
    for (int i = 0; i < 8; i++) cyc(1, 0, 8'h00, 0, 1, t);

    set_cal(6'h03); do_reset();
    n = 0;
    for (int i = 0; i < 2*WIN; i++) begin cyc(1, 0, 8'h00, 0, 0, t); n += int'(t); end
    chk("R7 ticks over two windows", n, ticks_over(2, 3, 0));

    for (int i = 0; i < 60000; i++) begin
      logic en, w, al;
      logic [7:0] a, d;
      int r = $urandom_range(0, 999);
      en = ($urandom_range(0, 3) != 0);
      al = 1'($urandom_range(0, 1));
      w = (r < 6);
      a = 8'($urandom_range(0, 2));
      d = 8'($urandom);
      if (a == 8'h00 && $urandom_range(0, 7) != 0) d[7] = 1'b0;
      cyc(en, w, a, d, al, t);
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule